// File: doc/BRIEF.md
# Bit test and modify execution unit

This unit executes the four bit-test instructions whose destination is a register. It receives the second opcode byte, the three-bit reg field of the ModRM byte, an 8-bit immediate, a register-supplied bit offset, the operand value and an operand-size flag. The operation is decoded from one of two encodings: the register-offset form or the immediate form. The unit selects one bit of the operand. It returns the original value of that bit as a carry flag and, for the modifying operations, returns the operand with that bit set, cleared or inverted, together with a write-enable.

All outputs are registered. An operation presented with `in_valid` high shows its results one clock later, with `out_valid` high. The carry flag is a held state: only an accepted bit-test operation changes it. An encoding the unit does not recognise raises `bad_op` and leaves the carry unchanged.

Top module: `bit_test_unit`

## Requirements
- R1: In the register-offset form, the opcode byte has the pattern 10TTT011 with T[2]=1. These are the bytes 0xA3, 0xAB, 0xB3 and 0xBB. The operation code is taken from opcode bits 5:3, and the bit offset from `offset_reg`.
- R2: In the immediate form, the opcode byte is 0xBA. The operation code is `modrm_reg`, and the bit offset is `imm`.
- R3: For an accepted operation, `carry` shows the value the selected bit had before any change. It is registered one cycle after `in_valid`, and keeps that value until the next accepted operation.
- R4: The bit index is the unsigned offset modulo 32 when `size32`=1 and modulo 16 when `size32`=0. Bit 0 is the least significant bit of the operand.
- R5: Operation code 100 (test) gives `wr_en`=0, and `result` equals the input operand.
- R6: Operation codes 101 (set), 110 (clear) and 111 (invert) give `wr_en`=1. `result` is the operand with only the selected bit forced to 1, forced to 0 or inverted, respectively.
- R7: Any other encoding gives `bad_op`=1 and `wr_en`=0, leaves `carry` unchanged, and `result` equals the operand. This covers the byte 0xBA with `modrm_reg` from 000 to 011, and any byte outside the R1/R2 set.
- R8: With `size32`=0, `result[31:16]` equals `operand[31:16]`.
- R9: While reset is held, and in the first cycle after it, `out_valid`, `carry`, `wr_en`, `bad_op` and `result` are 0.
- R10: `out_valid` follows `in_valid` one cycle later. In a cycle with `out_valid`=0, `wr_en` and `bad_op` are 0, and `carry` and `result` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| opc_byte | input | 8 | Second opcode byte |
| modrm_reg | input | 3 | Reg field of the ModRM byte |
| imm | input | 8 | Immediate bit number |
| offset_reg | input | 32 | Bit offset from a register |
| operand | input | 32 | Destination operand value |
| size32 | input | 1 | 1 = 32-bit operand, 0 = 16-bit |
| out_valid | output | 1 | Results valid |
| carry | output | 1 | Selected bit before modification |
| result | output | 32 | Updated operand |
| wr_en | output | 1 | Destination write-enable |
| bad_op | output | 1 | Unrecognised encoding |

## Verification
The assertions compare registered outputs with the inputs of the previous cycle. They therefore assume that every input has a known value in any cycle where `in_valid` is high, and that reset is applied before the first operation. The bench changes all inputs at the falling edge and always drives them from defined values. It also drives idle cycles with random operand data, so that the hold behaviour is exercised.

// File: rtl/bit_test_unit.sv
module bit_test_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [7:0]   opc_byte,
  input  logic [2:0]   modrm_reg,
  input  logic [7:0]   imm,
  input  logic [W-1:0] offset_reg,
  input  logic [W-1:0] operand,
  input  logic         size32,
  output logic         out_valid,
  output logic         carry,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         bad_op
);
  localparam int IW = $clog2(W);

  logic          form_imm, form_reg, accept;
  logic [2:0]    op;
  logic [7:0]    off8;
  logic [IW-1:0] idx;
  logic [W-1:0]  mask, modified;
  logic          old_bit;

  assign form_imm = (opc_byte == 8'hBA);
  assign form_reg = (opc_byte[7:6] == 2'b10) && (opc_byte[2:0] == 3'b011) && opc_byte[5];
  assign op       = form_imm ? modrm_reg : opc_byte[5:3];
  assign accept   = form_reg || (form_imm && modrm_reg[2]);
  assign off8     = form_imm ? imm : offset_reg[7:0];
  assign idx      = size32 ? off8[IW-1:0] : {1'b0, off8[IW-2:0]};
  assign mask     = {{(W-1){1'b0}}, 1'b1} << idx;
  assign old_bit  = operand[idx];

  always_comb begin
    unique case (op[1:0])
      2'b01:   modified = operand | mask;
      2'b10:   modified = operand & ~mask;
      2'b11:   modified = operand ^ mask;
      default: modified = operand;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      carry     <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      bad_op    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && accept && (op[1:0] != 2'b00);
      bad_op    <= in_valid && !accept;
      if (in_valid) result <= accept ? modified : operand;
      if (in_valid && accept) carry <= old_bit;
    end
  end

  AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || bad_op) |-> out_valid); // R10
  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> !wr_en && (result == $past(operand))); // R7
  AST_BAD_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> $stable(carry)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(carry) && $stable(result)); // R10
  AST_ONE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(result ^ $past(operand)) <= 1); // R6
  AST_NO_WRITE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wr_en) |-> result == $past(operand)); // R5
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(size32)) |-> result[W-1:W/2] == $past(operand[W-1:W/2])); // R8
endmodule

// File: tb/tb_bit_test_unit.sv
module tb_bit_test_unit;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, size32 = 1'b1;
  logic [7:0] opc_byte = 8'h0, imm = 8'h0;
  logic [2:0] modrm_reg = 3'h0;
  logic [31:0] offset_reg = '0, operand = '0;
  logic out_valid, carry, wr_en, bad_op;
  logic [31:0] result;

  int tests = 0, fails = 0;
  bit e_valid = 0, e_carry = 0, e_we = 0, e_bad = 0;
  logic [31:0] e_res = '0;
  bit done = 0;

  always #2 clk = ~clk;

  bit_test_unit dut (.*);

  task automatic check(string tag);
    tests++;
    if (out_valid !== e_valid || carry !== e_carry || result !== e_res ||
        wr_en !== e_we || bad_op !== e_bad) begin
      fails++;
      $display("FAIL %s: got v=%b c=%b r=%h we=%b bad=%b exp v=%b c=%b r=%h we=%b bad=%b",
               tag, out_valid, carry, result, wr_en, bad_op,
               e_valid, e_carry, e_res, e_we, e_bad);
    end
  endtask

  // behavioural reference applied to the values being driven
  task automatic model();
    bit ok, isimm;
    int op, off, idx;
    isimm = (opc_byte == 8'hBA);
    ok = (opc_byte == 8'hA3 || opc_byte == 8'hAB || opc_byte == 8'hB3 ||
          opc_byte == 8'hBB) || (isimm && modrm_reg >= 4);
    op  = isimm ? int'(modrm_reg) : int'(opc_byte[5:3]);
    off = isimm ? int'(imm) : int'(offset_reg % 256);
    idx = size32 ? off % 32 : off % 16;
    e_valid = in_valid;
    e_we = 0; e_bad = 0;
    if (in_valid) begin
      e_bad = !ok;
      e_res = operand;
      if (ok) begin
        e_carry = operand[idx];
        if (op == 5) e_res[idx] = 1'b1;
        if (op == 6) e_res[idx] = 1'b0;
        if (op == 7) e_res[idx] = ~operand[idx];
        e_we = (op != 4);
      end
    end
  endtask

  task automatic step(bit v, logic [7:0] ob, logic [2:0] mr, logic [7:0] im,
                      logic [31:0] ofr, logic [31:0] opd, bit s32, string tag);
    @(negedge clk);
    in_valid = v; opc_byte = ob; modrm_reg = mr; imm = im;
    offset_reg = ofr; operand = opd; size32 = s32;
    model();
    @(negedge clk);
    check(tag);
    in_valid = 0;
    model();
  endtask

  initial begin
    #20000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hang exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset");
    rst_n = 1;
    @(negedge clk);
    check("R9 after reset");
    // R1 register form, each operation
    step(1, 8'hA3, 0, 0, 32'd5,  32'h0000_0020, 1, "R1 R5 bt reg");
    step(1, 8'hAB, 0, 0, 32'd7,  32'h0000_0000, 1, "R1 R6 bts reg");
    step(1, 8'hB3, 0, 0, 32'd31, 32'hFFFF_FFFF, 1, "R1 R6 btr reg");
    step(1, 8'hBB, 0, 0, 32'd0,  32'h1234_5678, 1, "R1 R6 btc reg");
    // R2 immediate form
    step(1, 8'hBA, 4, 8'd3,  32'd0, 32'h0000_0008, 1, "R2 R3 bt imm");
    step(1, 8'hBA, 5, 8'd12, 32'd9, 32'h0, 1, "R2 bts imm");
    step(1, 8'hBA, 6, 8'd1,  32'd0, 32'hF, 1, "R2 btr imm");
    step(1, 8'hBA, 7, 8'd30, 32'd0, 32'h0, 1, "R2 btc imm");
    // R4 modulo
    step(1, 8'hBA, 7, 8'd33,  0, 32'h0, 1, "R4 imm mod32");
    step(1, 8'hBA, 7, 8'd33,  0, 32'h0, 0, "R4 imm mod16");
    step(1, 8'hBB, 0, 0, 32'hFFFF_FFFF, 32'h0, 0, "R4 R8 reg -1 mod16");
    step(1, 8'hBB, 0, 0, 32'hFFFF_FFFF, 32'h0, 1, "R4 reg -1 mod32");
    step(1, 8'hAB, 0, 0, 32'd255, 32'hABCD_0000, 0, "R4 R8 off255 16");
    // R7 invalid encodings keep carry
    step(1, 8'hBA, 7, 8'd0, 0, 32'h1, 1, "R3 set carry");
    step(1, 8'hBA, 3, 8'd0, 0, 32'h0, 1, "R7 imm op 011");
    step(1, 8'hBA, 0, 8'd0, 0, 32'h0, 1, "R7 imm op 000");
    step(1, 8'h83, 0, 0, 0, 32'h0, 1, "R7 byte 83");
    step(1, 8'hA0, 0, 0, 0, 32'h5, 1, "R7 byte A0");
    // R10 idle cycle with noisy inputs
    step(0, 8'hAB, 0, 0, 0, 32'hFFFF_FFFF, 1, "R10 idle");
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ob;
      case ($urandom % 6)
        0: ob = 8'hA3; 1: ob = 8'hAB; 2: ob = 8'hB3; 3: ob = 8'hBB;
        4: ob = 8'hBA; default: ob = 8'($urandom);
      endcase
      step(($urandom % 5) != 0, ob, 3'($urandom), 8'($urandom), $urandom,
           $urandom, 1'($urandom), "R6 R8 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule